// File: doc/BRIEF.md
# ADC Result Window Comparator

This block sits after a 10-bit analog-to-digital converter. Each time a conversion finishes, it turns the raw sample into a 16-bit result word. The word is either right-justified, with the value in the low bits, or left-justified, with the value in the top bits. The block then compares that word against two programmable 16-bit thresholds: an "above" bound and a "below" bound.

A matching compare sets a sticky window flag, and the flag stays set until software clears it. The order of the two thresholds selects what counts as a match:

- If the below bound is larger than the above bound, a match is a word strictly between them.
- Otherwise, a match is a word strictly greater than the above bound or strictly less than the below bound.

Software loads the thresholds one byte at a time. The interrupt request is the flag gated by an enable input.

Top module: `adc_window_cmp`

## Requirements
- R1: After synchronous reset, `result_word` is 0x0000, `win_flag` is 0, the above bound is 0xFFFF and the below bound is 0x0000. With these bounds no conversion result can set the flag.
- R2: When `left_just` is 0 on a cycle with `conv_done` high, `result_word` becomes `{6'b0, conv_value}` at the next clock edge.
- R3: When `left_just` is 1 on a cycle with `conv_done` high, `result_word` becomes `{conv_value, 6'b0}` at the next clock edge. Full scale is then 0xFFC0.
- R4: `result_word` keeps its value on every cycle where `conv_done` is low.
- R5: When the below bound is greater than the above bound, a conversion sets `win_flag` if and only if above < word < below, with both comparisons strict and unsigned.
- R6: When the below bound is less than or equal to the above bound, a conversion sets `win_flag` if and only if word > above or word < below. A word equal to either bound does not set it.
- R7: A conversion that does not match leaves `win_flag` unchanged. A compare never clears the flag.
- R8: `flag_clr` high clears `win_flag` at the next edge. If a matching conversion occurs in the same cycle, the flag is set instead.
- R9: Threshold writes are byte-wide through `thr_wr_sel` when `thr_wr_en` is high:
  - 0 selects the above bound's low byte.
  - 1 selects the above bound's high byte.
  - 2 selects the below bound's low byte.
  - 3 selects the below bound's high byte.

  A write changes only the selected byte.
- R10: `win_irq` equals `win_flag AND irq_en` in the same cycle.
- R11: The flag can rise only at an edge following a cycle with `conv_done` high. Changes on `conv_value` without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion result is valid |
| conv_value | input | 10 | Unsigned conversion sample |
| left_just | input | 1 | 1 = left-justified result word, 0 = right-justified |
| thr_wr_en | input | 1 | Threshold byte write enable |
| thr_wr_sel | input | 2 | Threshold byte select (see R9) |
| thr_wr_data | input | 8 | Threshold byte write data |
| flag_clr | input | 1 | Clears the window flag |
| irq_en | input | 1 | Interrupt enable |
| result_word | output | 16 | Formatted result of the last conversion |
| win_flag | output | 1 | Sticky window-match flag |
| win_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `conv_done` lasts exactly one cycle per conversion. They also assume that `conv_value` and `left_just` are stable while the strobe is high, because the properties relate the word after the edge to the sample taken in that cycle.

The stimulus drives all inputs at the falling edge and raises `conv_done` for exactly one cycle per conversion. It always rewrites all four threshold bytes before it switches between inside and outside detection. The bench's own model of the bounds therefore never diverges from a half-updated register.

// File: rtl/adcwin_pkg.sv
`timescale 1ns/1ps
package adcwin_pkg;
    parameter int SAMPLE_W = 10;
    parameter int WORD_W   = 16;
    parameter int BYTE_W   = 8;

    localparam int PAD_W  = WORD_W - SAMPLE_W;
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int SEL_W  = BIDX_W + 1;

    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [BYTE_W-1:0]   byte_t;

    typedef enum logic {JUST_RIGHT = 1'b0, JUST_LEFT = 1'b1} just_e;
    typedef enum logic {WIN_OUTSIDE = 1'b0, WIN_INSIDE = 1'b1} win_mode_e;

    typedef struct packed {
        word_t above;
        word_t below;
    } bounds_t;

    typedef struct packed {
        logic over_above;
        logic under_below;
        win_mode_e mode;
    } cmp_flags_t;

    localparam word_t ABOVE_RST = '1;
    localparam word_t BELOW_RST = '0;

    function automatic word_t format_word(input sample_t s, input just_e j);
        word_t w;
        if (j == JUST_LEFT) w = {s, {PAD_W{1'b0}}};
        else                w = {{PAD_W{1'b0}}, s};
        return w;
    endfunction

    function automatic win_mode_e pick_mode(input bounds_t b);
        return (b.below > b.above) ? WIN_INSIDE : WIN_OUTSIDE;
    endfunction
endpackage

// File: rtl/adcwin_result_stage.sv
`timescale 1ns/1ps
module adcwin_result_stage
    import adcwin_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    conv_done,
    input  sample_t sample,
    input  logic    left_just,
    output word_t   fmt_now,
    output word_t   result_q
);
    always_comb begin
        fmt_now = format_word(sample, just_e'(left_just));
    end

    always_ff @(posedge clk) begin
        if (rst)            result_q <= '0;
        else if (conv_done) result_q <= fmt_now;
    end
endmodule

// File: rtl/adcwin_thresholds.sv
`timescale 1ns/1ps
module adcwin_thresholds
    import adcwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  byte_t            wr_data,
    output bounds_t          bounds
);
    word_t above_q;
    word_t below_q;

    logic             sel_below;
    logic [BIDX_W-1:0] sel_byte;

    always_comb begin
        sel_below = wr_sel[SEL_W-1];
        sel_byte  = wr_sel[BIDX_W-1:0];
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        localparam logic [BIDX_W-1:0] IDX = BIDX_W'(g);

        always_ff @(posedge clk) begin
            if (rst)
                above_q[g*BYTE_W +: BYTE_W] <= ABOVE_RST[g*BYTE_W +: BYTE_W];
            else if (wr_en && !sel_below && sel_byte == IDX)
                above_q[g*BYTE_W +: BYTE_W] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                below_q[g*BYTE_W +: BYTE_W] <= BELOW_RST[g*BYTE_W +: BYTE_W];
            else if (wr_en && sel_below && sel_byte == IDX)
                below_q[g*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    always_comb begin
        bounds.above = above_q;
        bounds.below = below_q;
    end
endmodule

// File: rtl/adcwin_decide.sv
`timescale 1ns/1ps
module adcwin_decide
    import adcwin_pkg::*;
(
    input  word_t   word,
    input  bounds_t bounds,
    output logic    hit
);
    cmp_flags_t f;

    always_comb begin
        f.over_above  = word > bounds.above;
        f.under_below = word < bounds.below;
        f.mode        = pick_mode(bounds);
        if (f.mode == WIN_INSIDE) hit = f.over_above & f.under_below;
        else                      hit = f.over_above | f.under_below;
    end
endmodule

// File: rtl/adc_window_cmp.sv
`timescale 1ns/1ps
module adc_window_cmp
    import adcwin_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_value,
    input  logic                left_just,
    input  logic                thr_wr_en,
    input  logic [SEL_W-1:0]    thr_wr_sel,
    input  logic [BYTE_W-1:0]   thr_wr_data,
    input  logic                flag_clr,
    input  logic                irq_en,
    output logic [WORD_W-1:0]   result_word,
    output logic                win_flag,
    output logic                win_irq
);
    word_t   fmt_now;
    word_t   result_q;
    bounds_t bounds;
    logic    hit;
    logic    flag_q;

    adcwin_result_stage i_stage (
        .clk      (clk),
        .rst      (rst),
        .conv_done(conv_done),
        .sample   (conv_value),
        .left_just(left_just),
        .fmt_now  (fmt_now),
        .result_q (result_q)
    );

    adcwin_thresholds i_thr (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (thr_wr_en),
        .wr_sel (thr_wr_sel),
        .wr_data(thr_wr_data),
        .bounds (bounds)
    );

    adcwin_decide i_decide (
        .word  (fmt_now),
        .bounds(bounds),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst)                  flag_q <= 1'b0;
        else if (conv_done && hit) flag_q <= 1'b1;
        else if (flag_clr)        flag_q <= 1'b0;
    end

    always_comb begin
        result_word = result_q;
        win_flag    = flag_q;
        win_irq     = flag_q & irq_en;
    end
endmodule

// File: rtl/adcwin_chk.sv
`timescale 1ns/1ps
module adcwin_chk
    import adcwin_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                conv_done,
    input logic [SAMPLE_W-1:0] conv_value,
    input logic                left_just,
    input logic                flag_clr,
    input logic [WORD_W-1:0]   result_word,
    input logic                win_flag
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (result_word == '0 && !win_flag));

    // R2
    right_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !left_just) |=> result_word == {{PAD_W{1'b0}}, $past(conv_value)});

    // R3
    left_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && left_just) |=> result_word == {$past(conv_value), {PAD_W{1'b0}}});

    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(result_word));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (win_flag && !flag_clr) |=> win_flag);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !conv_done) |=> !win_flag);

    // R11
    rise_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> !$rose(win_flag));
endmodule

bind adc_window_cmp adcwin_chk i_adcwin_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_done  (conv_done),
    .conv_value (conv_value),
    .left_just  (left_just),
    .flag_clr   (flag_clr),
    .result_word(result_word),
    .win_flag   (win_flag)
);

// File: tb/test_adc_window_cmp.sv
`timescale 1ns/1ps
module test_adc_window_cmp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [9:0]  conv_value = '0;
    logic        left_just = 1'b0;
    logic        thr_wr_en = 1'b0;
    logic [1:0]  thr_wr_sel = '0;
    logic [7:0]  thr_wr_data = '0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] result_word;
    logic        win_flag;
    logic        win_irq;

    int checks = 0;
    int failures = 0;
    logic [15:0] m_above = 16'hFFFF;
    logic [15:0] m_below = 16'h0000;

    always #2 clk = ~clk;

    adc_window_cmp i_adc_window_cmp (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_value(conv_value),
        .left_just(left_just), .thr_wr_en(thr_wr_en), .thr_wr_sel(thr_wr_sel),
        .thr_wr_data(thr_wr_data), .flag_clr(flag_clr), .irq_en(irq_en),
        .result_word(result_word), .win_flag(win_flag), .win_irq(win_irq)
    );

    task automatic check(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [15:0] w);
        if (m_below > m_above) return (w > m_above) && (w < m_below);
        return (w > m_above) || (w < m_below);
    endfunction

    function automatic logic [15:0] model_fmt(input logic [9:0] v, input logic lj);
        return lj ? {v, 6'b0} : {6'b0, v};
    endfunction

    task automatic wr_byte(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        thr_wr_en = 1'b1; thr_wr_sel = sel; thr_wr_data = d;
        @(negedge clk);
        thr_wr_en = 1'b0;
        case (sel)
            2'd0: m_above[7:0]  = d;
            2'd1: m_above[15:8] = d;
            2'd2: m_below[7:0]  = d;
            default: m_below[15:8] = d;
        endcase
    endtask

    task automatic set_bounds(input logic [15:0] above, input logic [15:0] below);
        wr_byte(2'd0, above[7:0]);
        wr_byte(2'd1, above[15:8]);
        wr_byte(2'd2, below[7:0]);
        wr_byte(2'd3, below[15:8]);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic convert(input logic [9:0] v, input logic lj);
        @(negedge clk);
        conv_done = 1'b1; conv_value = v; left_just = lj;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic probe(input logic [9:0] v, input logic lj, input string req);
        logic [15:0] w;
        w = model_fmt(v, lj);
        clear_flag();
        convert(v, lj);
        check(result_word == w, lj ? "R3 format" : "R2 format", result_word, w);
        check(win_flag == model_hit(w), req, {15'b0, win_flag}, {15'b0, model_hit(w)});
    endtask

    task automatic t_reset();
        irq_en = 1'b1;
        check(result_word == 16'h0, "R1 result", result_word, 16'h0);
        check(win_flag == 1'b0, "R1 flag", {15'b0, win_flag}, 16'h0);
        check(win_irq == 1'b0, "R1 irq", {15'b0, win_irq}, 16'h0);
        foreach (m_above[i]) begin end
        convert(10'h000, 1'b0);
        check(win_flag == 1'b0, "R1 zero no set", {15'b0, win_flag}, 16'h0);
        convert(10'h3FF, 1'b1);
        check(win_flag == 1'b0, "R1 full no set", {15'b0, win_flag}, 16'h0);
        check(result_word == 16'hFFC0, "R3 full scale", result_word, 16'hFFC0);
        irq_en = 1'b0;
    endtask

    task automatic t_inside();
        logic [9:0] vals [8] = '{10'h03F, 10'h040, 10'h041, 10'h07F, 10'h080, 10'h081, 10'h000, 10'h3FF};
        set_bounds(16'h0040, 16'h0080);
        foreach (vals[i]) probe(vals[i], 1'b0, "R5 inside");
    endtask

    task automatic t_outside();
        logic [9:0] vals [6] = '{10'h03F, 10'h040, 10'h060, 10'h080, 10'h081, 10'h000};
        set_bounds(16'h0080, 16'h0040);
        foreach (vals[i]) probe(vals[i], 1'b0, "R6 outside");
        set_bounds(16'h0100, 16'h0100);
        probe(10'h100, 1'b0, "R6 equal bounds at bound");
        probe(10'h0FF, 1'b0, "R6 equal bounds below");
        probe(10'h101, 1'b0, "R6 equal bounds above");
    endtask

    task automatic t_left();
        set_bounds(16'h1000, 16'h2000);
        probe(10'h040, 1'b1, "R5 left at lower bound");
        probe(10'h041, 1'b1, "R5 left inside");
        probe(10'h07F, 1'b1, "R5 left top inside");
        probe(10'h080, 1'b1, "R5 left at upper bound");
    endtask

    task automatic t_sticky_and_strobe();
        logic [15:0] held;
        set_bounds(16'h0040, 16'h0080);
        clear_flag();
        convert(10'h050, 1'b0);
        check(win_flag == 1'b1, "R5 set", {15'b0, win_flag}, 16'h1);
        convert(10'h010, 1'b0);
        check(win_flag == 1'b1, "R7 miss keeps flag", {15'b0, win_flag}, 16'h1);
        clear_flag();
        check(win_flag == 1'b0, "R8 clear", {15'b0, win_flag}, 16'h0);
        held = result_word;
        @(negedge clk);
        conv_value = 10'h060; left_just = 1'b1;
        repeat (3) @(negedge clk);
        check(win_flag == 1'b0, "R11 no strobe no set", {15'b0, win_flag}, 16'h0);
        check(result_word == held, "R4 hold", result_word, held);
    endtask

    task automatic t_set_wins();
        set_bounds(16'h0040, 16'h0080);
        clear_flag();
        convert(10'h050, 1'b0);
        @(negedge clk);
        flag_clr = 1'b1; conv_done = 1'b1; conv_value = 10'h055; left_just = 1'b0;
        @(negedge clk);
        flag_clr = 1'b0; conv_done = 1'b0;
        check(win_flag == 1'b1, "R8 set wins", {15'b0, win_flag}, 16'h1);
        @(negedge clk);
        flag_clr = 1'b1; conv_done = 1'b1; conv_value = 10'h010;
        @(negedge clk);
        flag_clr = 1'b0; conv_done = 1'b0;
        check(win_flag == 1'b0, "R8 clear with miss", {15'b0, win_flag}, 16'h0);
    endtask

    task automatic t_irq();
        set_bounds(16'h0040, 16'h0080);
        convert(10'h050, 1'b0);
        irq_en = 1'b0; #1;
        check(win_irq == 1'b0, "R10 masked", {15'b0, win_irq}, 16'h0);
        irq_en = 1'b1; #1;
        check(win_irq == 1'b1, "R10 enabled", {15'b0, win_irq}, 16'h1);
        clear_flag();
        check(win_irq == 1'b0, "R10 cleared", {15'b0, win_irq}, 16'h0);
        irq_en = 1'b0;
    endtask

    task automatic t_byte_write();
        set_bounds(16'h0040, 16'h0080);
        wr_byte(2'd3, 8'h01);
        probe(10'h100, 1'b0, "R9 below high byte only");
        probe(10'h030, 1'b0, "R9 above untouched");
        wr_byte(2'd0, 8'hF0);
        probe(10'h0F0, 1'b0, "R9 above low byte only");
        probe(10'h0F1, 1'b0, "R9 above low byte only");
    endtask

    initial begin : watchdog
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_inside();
        t_outside();
        t_left();
        t_sticky_and_strobe();
        t_set_wins();
        t_irq();
        t_byte_write();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule